// File: doc/BRIEF.md
# Clock Ratio Transition Sequencer

This block moves a processor core between clock ratios of 1, 2, 4, 6 and 8 without leaving the DRAM refresh settings out of step with the new clock. A request carries a ratio index. The block then writes the divider mode field, the refresh count and the self-refresh enable bit it owns, in an order fixed by the direction of the change. After each mode write it waits for the clock generator to settle. Where refresh timing could lapse, it also waits for the old and new refresh intervals to drain.

A move between ratio 1 and any ratio above 2 is never made in one step. It always passes through ratio 2, which is the only ratio where self-refresh is switched on or off. The base clock frequency is a parameter, and the refresh count for each ratio is derived from it when the block is built. The clock generator, the DRAM and any register bus sit outside this block. The block drives its state on plain output ports.

Top module: `clk_ratio_sequencer`

## Requirements
- R1: Ratio index 0,1,2,3,4 selects divisor 1,2,4,6,8, and the mode output takes the code 3'b000, 3'b001, 3'b011, 3'b010, 3'b100 respectively. The mode output never holds any other code.
- R2: The memory control word holds the refresh count in bits 14:8 and self-refresh enable in bit 16. The count written for divisor d is floor(BASE_HZ × 7800 / (64 × d × 10^9)). Every other bit keeps its reset value.
- R3: A change from ratio 2 to ratio 1 clears self-refresh, then writes the mode, then writes the refresh count, with no drain wait.
- R4: A change from ratio 1 to ratio 2 writes the refresh count, waits for the drain, then writes the mode, then sets self-refresh.
- R5: A change from ratio 1 to ratio 4, 6 or 8 passes through ratio 2, and so does a change from ratio 4, 6 or 8 to ratio 1.
- R6: Any other increase of the divisor writes the refresh count and then the mode. Any other decrease writes the mode and then the refresh count.
- R7: After every mode write, mode and memory control word stay unchanged for at least PLL_CYCLES (16) cycles.
- R8: A drain wait happens only when self-refresh is clear after the count update. It lasts at least 64 × (new count + old count) × old divisor cycles.
- R9: A request for the ratio already in force writes nothing and still ends with done.
- R10: busy is high from the cycle after an accepted start until done. Start requests while busy are ignored. done is high for exactly one cycle.
- R11: A ratio index above 4 gives a one-cycle err pulse and changes no output.
- R12: After reset, mode is 3'b000, the refresh count is the divisor-1 value, self-refresh is clear, and busy, done and err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a ratio change (sampled when idle) |
| target_idx | input | 3 | Requested ratio index, 0 to 4 |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse at the end of a sequence |
| err | output | 1 | One-cycle pulse for a rejected index |
| mode | output | 3 | Divider mode code |
| mem_ctrl | output | MCW_W (32) | Memory control word: refresh count and self-refresh enable |

## Verification
The bench builds the block with a 200 MHz base clock. This gives refresh counts of 24, 12, 6, 4 and 3, all distinct, so every count write shows up as a change at the ports, and a divisor-1 drain lasts only about 2,300 cycles. PLL_CYCLES stays at 16 and MARGIN at 4. The reset value of the memory control word has other bits set, so any disturbance of them is visible. A table of requests walks through every kind of hop, including both bridged routes, and checks the order of the writes and the spacing between them. Directed tests then cover an index out of range, a start pulse while busy, and the reset state.

// File: rtl/ratio_pkg.sv
package ratio_pkg;
  localparam int NUM_RATIOS = 5;

  typedef logic [2:0] mode_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PLAN, ST_SR_CLR, ST_MODE, ST_PLL,
    ST_REF, ST_DRAIN, ST_SR_SET, ST_DONE
  } seq_st_t;

  typedef enum logic [1:0] {HOP_DN1, HOP_UP1, HOP_UP, HOP_DN} hop_t;

  function automatic mode_t idx_to_mode(input logic [2:0] i);
    case (i)
      3'd0:    return 3'b000;
      3'd1:    return 3'b001;
      3'd2:    return 3'b011;
      3'd3:    return 3'b010;
      3'd4:    return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

  function automatic logic [3:0] idx_to_div(input logic [2:0] i);
    case (i)
      3'd0:    return 4'd1;
      3'd1:    return 4'd2;
      3'd2:    return 4'd4;
      3'd3:    return 4'd6;
      3'd4:    return 4'd8;
      default: return 4'd1;
    endcase
  endfunction

  function automatic logic [2:0] mode_to_idx(input mode_t m);
    case (m)
      3'b000:  return 3'd0;
      3'b001:  return 3'd1;
      3'b011:  return 3'd2;
      3'b010:  return 3'd3;
      3'b100:  return 3'd4;
      default: return 3'd7;
    endcase
  endfunction

  function automatic int unsigned refresh_count(input longint unsigned hz,
                                                input int unsigned div);
    return 32'((hz * 64'd7800) / (64'd64 * 64'(div) * 64'd1000000000));
  endfunction
endpackage

// File: rtl/ratio_refresh_calc.sv
module ratio_refresh_calc import ratio_pkg::*; #(
  parameter longint unsigned BASE_HZ = 400_000_000,
  parameter int CNT_W = 7
) (
  input  logic [2:0]       idx,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] tbl [8];

  for (genvar i = 0; i < 8; i++) begin : g_tbl
    localparam int unsigned VAL = refresh_count(BASE_HZ, 32'(idx_to_div(3'(i))));
    assign tbl[i] = VAL[CNT_W-1:0];
  end

  assign count = tbl[idx];
endmodule

// File: rtl/ratio_wait_timer.sv
module ratio_wait_timer #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/clk_ratio_sequencer.sv
module clk_ratio_sequencer import ratio_pkg::*; #(
  parameter longint unsigned BASE_HZ = 400_000_000,
  parameter int MCW_W = 32,
  parameter logic [MCW_W-1:0] MCW_RESET = 32'h5A5E_0081,
  parameter int PLL_CYCLES = 16,
  parameter int MARGIN = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [2:0]       target_idx,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [2:0]       mode,
  output logic [MCW_W-1:0] mem_ctrl
);
  localparam int CNT_W   = 7;
  localparam int CNT_LSB = 8;
  localparam int SR_BIT  = 16;
  localparam int TW      = CNT_W + 1 + 4 + 6;
  localparam logic [2:0] MAX_IDX = 3'(NUM_RATIOS - 1);
  localparam logic [MCW_W-1:0] CNT_MASK  = MCW_W'({CNT_W{1'b1}}) << CNT_LSB;
  localparam logic [MCW_W-1:0] SR_MASK   = MCW_W'(1) << SR_BIT;
  localparam logic [MCW_W-1:0] KEEP_MASK = ~(CNT_MASK | SR_MASK);
  localparam logic [CNT_W-1:0] RST_CNT   = CNT_W'(refresh_count(BASE_HZ, 1));
  localparam logic [MCW_W-1:0] RST_WORD  =
    (MCW_RESET & KEEP_MASK) | (MCW_W'(RST_CNT) << CNT_LSB);

  seq_st_t          state;
  hop_t             hop, plan_hop;
  logic [2:0]       tgt_idx, hop_idx, plan_idx, cur_idx;
  logic [3:0]       from_div;
  mode_t            mode_q;
  logic [MCW_W-1:0] mcw_q;
  logic             err_q;
  logic [CNT_W-1:0] new_cnt, old_cnt;
  logic [TW-1:0]    drain_len, tmr_val;
  logic             need_drain, tmr_load, tmr_expired, bridge;
  seq_st_t          after_ref;

  ratio_refresh_calc #(.BASE_HZ(BASE_HZ), .CNT_W(CNT_W)) u_calc (
    .idx(hop_idx), .count(new_cnt)
  );

  ratio_wait_timer #(.W(TW)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val),
    .expired(tmr_expired)
  );

  assign cur_idx = mode_to_idx(mode_q);
  assign old_cnt = mcw_q[CNT_LSB +: CNT_W];

  // Route between ratio 1 and anything slower than ratio 2 through ratio 2
  always_comb begin
    bridge   = (cur_idx == 3'd0 && tgt_idx > 3'd1) ||
               (cur_idx > 3'd1 && tgt_idx == 3'd0);
    plan_idx = bridge ? 3'd1 : tgt_idx;
    if (cur_idx == 3'd1 && plan_idx == 3'd0)      plan_hop = HOP_DN1;
    else if (cur_idx == 3'd0 && plan_idx == 3'd1) plan_hop = HOP_UP1;
    else if (plan_idx > cur_idx)                  plan_hop = HOP_UP;
    else                                          plan_hop = HOP_DN;
  end

  assign need_drain = (hop == HOP_UP1 || hop == HOP_DN) && !mcw_q[SR_BIT];
  assign drain_len  = (TW'(new_cnt) + TW'(old_cnt)) * TW'(from_div) * TW'(64)
                      + TW'(MARGIN);
  assign tmr_load   = (state == ST_MODE) || (state == ST_REF && need_drain);
  assign tmr_val    = (state == ST_MODE) ? TW'(PLL_CYCLES) : drain_len;
  assign after_ref  = (hop == HOP_UP1 || hop == HOP_UP) ? ST_MODE : ST_PLAN;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      hop      <= HOP_UP;
      tgt_idx  <= '0;
      hop_idx  <= '0;
      from_div <= 4'd1;
      mode_q   <= 3'b000;
      mcw_q    <= RST_WORD;
      err_q    <= 1'b0;
    end else begin
      err_q <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          if (target_idx > MAX_IDX) err_q <= 1'b1;
          else begin
            tgt_idx <= target_idx;
            state   <= ST_PLAN;
          end
        end
        ST_PLAN: begin
          if (cur_idx == tgt_idx) state <= ST_DONE;
          else begin
            hop      <= plan_hop;
            hop_idx  <= plan_idx;
            from_div <= idx_to_div(cur_idx);
            case (plan_hop)
              HOP_DN1: state <= ST_SR_CLR;
              HOP_DN:  state <= ST_MODE;
              default: state <= ST_REF;
            endcase
          end
        end
        ST_SR_CLR: begin
          mcw_q[SR_BIT] <= 1'b0;
          state         <= ST_MODE;
        end
        ST_MODE: begin
          mode_q <= idx_to_mode(hop_idx);
          state  <= ST_PLL;
        end
        ST_PLL: if (tmr_expired) begin
          case (hop)
            HOP_UP1: state <= ST_SR_SET;
            HOP_UP:  state <= ST_PLAN;
            default: state <= ST_REF;
          endcase
        end
        ST_REF: begin
          mcw_q[CNT_LSB +: CNT_W] <= new_cnt;
          state <= need_drain ? ST_DRAIN : after_ref;
        end
        ST_DRAIN: if (tmr_expired) state <= after_ref;
        ST_SR_SET: begin
          mcw_q[SR_BIT] <= 1'b1;
          state         <= ST_PLAN;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (state != ST_IDLE);
  assign done     = (state == ST_DONE);
  assign err      = err_q;
  assign mode     = mode_q;
  assign mem_ctrl = mcw_q;

  assert_mode_legal_R1: assert property (@(posedge clk) disable iff (rst)
    mode_to_idx(mode_q) != 3'd7);
  assert_keep_bits_R2: assert property (@(posedge clk) disable iff (rst)
    $stable(mcw_q & KEEP_MASK));
  assert_pll_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PLL && !tmr_expired) |=> ($stable(mode_q) && $stable(mcw_q)));
  assert_drain_sr_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DRAIN) |-> !mcw_q[SR_BIT]);
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_bad_idx_R11: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && start && target_idx > MAX_IDX)
      |=> (err && $stable(mode_q) && $stable(mcw_q)));
endmodule

// File: tb/clk_ratio_sequencer_bench.sv
module clk_ratio_sequencer_bench;
  localparam logic [31:0] RST_OTHER = 32'h5A5E_0081;
  localparam logic [31:0] KEEP = ~32'h0001_7F00;
  // {idx, mode, count, sr, event sequence (1=count, 2=mode, 3=self-refresh)}
  localparam int NV = 7;
  localparam logic [45:0] VEC [NV] = '{
    {3'd1, 3'b001, 7'd12, 1'b1, 32'h123},
    {3'd2, 3'b011, 7'd6,  1'b1, 32'h12},
    {3'd4, 3'b100, 7'd3,  1'b1, 32'h12},
    {3'd3, 3'b010, 7'd4,  1'b1, 32'h21},
    {3'd0, 3'b000, 7'd24, 1'b0, 32'h21321},
    {3'd3, 3'b010, 7'd4,  1'b1, 32'h12312},
    {3'd3, 3'b010, 7'd4,  1'b1, 32'h0}
  };

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [2:0] target_idx = '0;
  logic busy, done, err;
  logic [2:0] mode;
  logic [31:0] mem_ctrl;

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;
  logic [31:0] seq;
  int ev_n, t1, t2, last_code, last_cyc, min_gap;
  logic [2:0] p_mode;
  logic [6:0] p_cnt;
  logic p_sr;
  bit got_done, got_err, done_after, busy_first;

  always #10 clk = ~clk;

  clk_ratio_sequencer #(.BASE_HZ(200_000_000), .MCW_W(32), .MCW_RESET(RST_OTHER),
    .PLL_CYCLES(16), .MARGIN(4)) u_clk_ratio_sequencer (
    .clk(clk), .rst(rst), .start(start), .target_idx(target_idx),
    .busy(busy), .done(done), .err(err), .mode(mode), .mem_ctrl(mem_ctrl));

  task automatic push(input int code);
    seq = (seq << 4) | 32'(code);
    ev_n++;
    if (ev_n == 1) t1 = cyc;
    if (ev_n == 2) t2 = cyc;
    if (last_code == 2 && (cyc - last_cyc) < min_gap) min_gap = cyc - last_cyc;
    last_code = code;
    last_cyc = cyc;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (mem_ctrl[14:8] != p_cnt) push(1);
      if (mode != p_mode) push(2);
      if (mem_ctrl[16] != p_sr) push(3);
    end
    p_mode = mode;
    p_cnt = mem_ctrl[14:8];
    p_sr = mem_ctrl[16];
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_log();
    seq = 0; ev_n = 0; t1 = 0; t2 = 0; last_code = 0; last_cyc = 0;
    min_gap = 1000000;
  endtask

  task automatic do_req(input logic [2:0] idx, input int poke_at,
                        input logic [2:0] poke_idx);
    int n = 0;
    clear_log();
    start = 1'b1; target_idx = idx;
    @(negedge clk); #1;
    start = 1'b0;
    busy_first = busy;
    while (!done && !err && n < 20000) begin
      if (n == poke_at) begin start = 1'b1; target_idx = poke_idx; end
      @(negedge clk); #1;
      start = 1'b0;
      n++;
    end
    got_done = done; got_err = err;
    @(negedge clk); #1;
    done_after = done | err;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;
    @(negedge clk); #1;
    // R12: reset state
    chk(mode == 3'b000, "R12", "reset mode", mode, 0);
    chk(mem_ctrl[14:8] == 7'd24, "R12", "reset count", mem_ctrl[14:8], 24);
    chk(mem_ctrl[16] == 1'b0, "R12", "reset self-refresh", mem_ctrl[16], 0);
    chk(!busy && !done && !err, "R12", "reset flags", {busy, done, err}, 0);
    chk((mem_ctrl & KEEP) == (RST_OTHER & KEEP), "R2", "reset other bits",
        mem_ctrl & KEEP, RST_OTHER & KEEP);

    for (int v = 0; v < NV; v++) begin
      do_req(VEC[v][45:43], -1, 3'd0);
      chk(got_done && !got_err, "R10", $sformatf("vec %0d done", v), got_done, 1);
      chk(!done_after, "R10", $sformatf("vec %0d done one cycle", v), done_after, 0);
      chk(busy_first, "R10", $sformatf("vec %0d busy", v), busy_first, 1);
      chk(mode == VEC[v][42:40], "R1", $sformatf("vec %0d mode", v), mode, VEC[v][42:40]);
      chk(mem_ctrl[14:8] == VEC[v][39:33], "R2", $sformatf("vec %0d count", v),
          mem_ctrl[14:8], VEC[v][39:33]);
      chk(mem_ctrl[16] == VEC[v][32], "R4", $sformatf("vec %0d self-refresh", v),
          mem_ctrl[16], VEC[v][32]);
      chk((mem_ctrl & KEEP) == (RST_OTHER & KEEP), "R2", $sformatf("vec %0d other bits", v),
          mem_ctrl & KEEP, RST_OTHER & KEEP);
      // R3 R4 R5 R6 R9: write order
      chk(seq == VEC[v][31:0], "R3/R4/R5/R6/R9", $sformatf("vec %0d order", v),
          seq, VEC[v][31:0]);
      if (min_gap != 1000000)
        chk(min_gap >= 16, "R7", $sformatf("vec %0d pll gap", v), min_gap, 16);
      if (v == 0)
        chk(t2 - t1 >= 64 * 36, "R8", "drain 1->2 length", t2 - t1, 64 * 36);
      if (v == 1)
        chk(t2 - t1 < 64, "R6", "no drain on increase", t2 - t1, 63);
      if (v == 3)
        chk(t2 - t1 < 64, "R8", "no drain with self-refresh set", t2 - t1, 63);
    end

    // R11: out-of-range index
    do_req(3'd5, -1, 3'd0);
    chk(got_err && !got_done, "R11", "err pulse", got_err, 1);
    chk(!done_after, "R11", "err one cycle", done_after, 0);
    chk(mode == 3'b010 && mem_ctrl[14:8] == 7'd4 && seq == 0, "R11", "no change",
        seq, 0);

    // R10: start while busy ignored (6 -> 1, poke with index 1)
    do_req(3'd0, 5, 3'd1);
    chk(got_done, "R10", "done with poke", got_done, 1);
    chk(seq == 32'h21321, "R10", "poke order", seq, 32'h21321);
    repeat (20) @(negedge clk);
    #1;
    chk(mode == 3'b000 && seq == 32'h21321 && !busy, "R10", "poke ignored", mode, 0);
    chk(mem_ctrl[14:8] == 7'd24 && !mem_ctrl[16], "R3", "final ratio 1 state",
        mem_ctrl[14:8], 24);

    // R12: reset after activity
    do_req(3'd4, -1, 3'd0);
    rst = 1'b1;
    @(negedge clk); #1;
    rst = 1'b0;
    chk(mode == 3'b000 && mem_ctrl[14:8] == 7'd24 && !mem_ctrl[16], "R12",
        "reset after activity", mode, 0);

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    wait (cyc >= 150000);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule